// File: doc/BRIEF.md
# Run/Stop Cycle Counter Peripheral

This block is a 32-bit cycle counter that a processor controls through a small memory-mapped slave port. Software can preset the count, read it back, and switch counting on or off. A dedicated read location returns the count and freezes the counter in the same access. That lets software take a timing measurement and halt the timer with a single load. The low-order bits of the count also leave the block on a plain output bus, so a bank of board LEDs can show the counter moving.

The port has two 32-bit words, selected by a single word-address bit. Every access covers the full word. A read answers exactly one cycle after it is issued, with a one-cycle valid pulse, and the port never stalls. The block sits in the system clock domain and takes its reset from the board's reference reset.

Top module: `tick_counter_periph`

## Requirements
- R1: After reset the count is 0, the counter is stopped, `rsp_valid` is 0, `rsp_data` is 0 and `led_out` is 0.
- R2: While running and not written, the count rises by exactly one at every clock edge and wraps from 32'hFFFF_FFFF to 0.
- R3: A write to word 0 (`bus_addr`=0) loads `bus_wdata` into the count at that edge, whether or not the counter is running. The load edge adds no increment. If the counter is running, counting continues from the loaded value at the next edge.
- R4: A write to word 1 looks only at `bus_wdata` bit 0. Bit 0 = 1 starts the counter, and the first increment comes at the edge after the write's edge. Bit 0 = 0 stops the counter, and no increment occurs at the write's edge. All other data bits have no effect.
- R5: A read of word 0 returns, in the following cycle, on `rsp_data` with `rsp_valid` high for that one cycle, the count as it stood in the read's cycle. It does not change the run state. `rsp_data` is 0 in every cycle in which `rsp_valid` is low.
- R6: A read of word 1 returns the count with the same timing as R5 and stops the counter at the same edge, so the counter then holds exactly the value returned.
- R7: `led_out` always equals the low `LED_W` bits of the current count.
- R8: When a read and a write are issued in the same cycle, the write takes effect as in R3/R4 and the read still returns the count from before that edge. A start written to word 1 overrides the stop that a read of word 1 would cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 1 | Word select: 0 = count, 1 = control |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| rsp_data | output | 32 | Read data, valid one cycle after the read |
| rsp_valid | output | 1 | Read data valid pulse |
| led_out | output | LED_W (27) | Low count bits for the LED banks |

## Verification
The bench goes after the edge-exact behaviour of start and stop. A design that let the stop edge still increment would return one value from the read-and-stop location and then hold a different one. A design that counted on the start edge itself would run one step ahead. Loads issued while running are checked for a missing or doubled increment on the load edge, and a preset just below 2^32 checks that the count wraps to zero. Simultaneous read and write cycles show whether a read-side stop wrongly beats a written start, and whether a write's new value leaks into the read data.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    localparam int unsigned REG_WORDS = 2;
    localparam int unsigned ADDR_W    = $clog2(REG_WORDS);

    typedef struct packed {
        logic load;     // preset the count from write data
        logic run_set;  // start counting
        logic run_clr;  // stop counting (written stop or read-and-halt)
        logic read;     // capture count for the response
    } tcp_cmd_t;
endpackage

// File: rtl/tcp_decode.sv
module tcp_decode
    import tcp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              wdata_lsb,
    output tcp_cmd_t          cmd
);
    logic sel_ctrl;

    always_comb begin
        sel_ctrl     = (addr == ADDR_W'(1));
        cmd          = '0;
        cmd.read     = rd;
        cmd.load     = wr && !sel_ctrl;
        cmd.run_set  = wr && sel_ctrl && wdata_lsb;
        // a written control word beats the halt side effect of a read
        cmd.run_clr  = (wr && sel_ctrl && !wdata_lsb) ||
                       (rd && !wr && sel_ctrl);
    end
endmodule

// File: rtl/tcp_counter.sv
module tcp_counter
    import tcp_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tcp_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.load)
            st_d.count = load_val;
        else if (st_q.run && !cmd.run_clr)
            st_d.count = st_q.count + CNT_W'(1);
        if (cmd.run_set)
            st_d.run = 1'b1;
        else if (cmd.run_clr)
            st_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign running = st_q.run;

    // R2: a running counter with no load or stop steps by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cmd.load && !cmd.run_clr) |=> (count == $past(count) + CNT_W'(1)));
    // R3: a load lands exactly the written value
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.load |=> (count == $past(load_val)));
    // R4: stopped counter without a load stays put
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cmd.load) |=> $stable(count));
    // R6: read-and-halt leaves the counter stopped
    a_r6_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.run_clr && !cmd.run_set) |=> !running);
endmodule

// File: rtl/tcp_resp.sv
module tcp_resp #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             read,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] rdata,
    output logic             rvalid
);
    typedef struct packed {
        logic [CNT_W-1:0] data;
        logic             valid;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d.valid = read;
        rsp_d.data  = read ? count : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rdata  = rsp_q.data;
    assign rvalid = rsp_q.valid;

    // R5: a read yields exactly one valid cycle, next cycle
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        read |=> rvalid);
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !read |=> (!rvalid && rdata == '0));
    a_r5_value: assert property (@(posedge clk) disable iff (!rst_n)
        read |=> (rdata == $past(count)));
endmodule

// File: rtl/tick_counter_periph.sv
module tick_counter_periph
    import tcp_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LED_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  rsp_data,
    output logic              rsp_valid,
    output logic [LED_W-1:0]  led_out
);
    tcp_cmd_t         cmd;
    logic [CNT_W-1:0] count;
    logic             running;

    tcp_decode u_decode (
        .addr      (bus_addr),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .wdata_lsb (bus_wdata[0]),
        .cmd       (cmd)
    );

    tcp_counter #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_val (bus_wdata),
        .count    (count),
        .running  (running)
    );

    tcp_resp #(.CNT_W(CNT_W)) u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .read   (cmd.read),
        .count  (count),
        .rdata  (rsp_data),
        .rvalid (rsp_valid)
    );

    generate
        if (LED_W <= CNT_W) begin : g_led_tap
            assign led_out = count[LED_W-1:0];
        end else begin : g_led_pad
            assign led_out = {{(LED_W-CNT_W){1'b0}}, count};
        end
    endgenerate

    // R8: a written start survives a simultaneous read of the control word
    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd && bus_addr == ADDR_W'(1) && bus_wdata[0]) |=> running);
    // R7: LED bank tracks the count
    a_r7_led: assert property (@(posedge clk) disable iff (!rst_n)
        led_out == LED_W'(count));
endmodule

// File: tb/tick_counter_periph_tb.sv
module tick_counter_periph_tb;
    localparam int unsigned CNT_W = 32;
    localparam int unsigned LED_W = 27;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [0:0]       bus_addr = '0;
    logic             bus_rd = 1'b0;
    logic             bus_wr = 1'b0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] rsp_data;
    logic             rsp_valid;
    logic [LED_W-1:0] led_out;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [CNT_W-1:0] val;
        string            tag;
    } exp_t;
    exp_t exp_q[$];

    logic [CNT_W-1:0] m_count = '0;
    logic             m_run   = 1'b0;
    bit               done    = 1'b0;

    tick_counter_periph #(.CNT_W(CNT_W), .LED_W(LED_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rsp_data(rsp_data),
        .rsp_valid(rsp_valid), .led_out(led_out)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one bus cycle; updates the reference model per the requirements
    task automatic cyc(input bit rd, input bit wr, input bit addr,
                       input logic [CNT_W-1:0] wd, input string tag);
        bit ld, clr, set;
        @(negedge clk);
        check(led_out == m_count[LED_W-1:0], "R7 led", CNT_W'(led_out), CNT_W'(m_count[LED_W-1:0]));
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        if (rd) exp_q.push_back('{val: m_count, tag: tag});
        ld  = wr && !addr;
        set = wr && addr && wd[0];
        clr = (wr && addr && !wd[0]) || (rd && !wr && addr);
        if (ld)                 m_count = wd;
        else if (m_run && !clr) m_count = m_count + 1;
        if (set)      m_run = 1'b1;
        else if (clr) m_run = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, "idle");
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected response", rsp_data, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_data == e.val, e.tag, rsp_data, e.val);
                end
            end else if (rsp_data != '0) begin
                check(1'b0, "R5 data while idle", rsp_data, '0);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                check(rsp_valid == 1'b0, "R1 valid after reset", CNT_W'(rsp_valid), '0);
                check(led_out == '0, "R1 led after reset", CNT_W'(led_out), '0);
                cyc(1, 0, 0, '0, "R1 count zero");
                idle(3);
                cyc(1, 0, 0, '0, "R1 stopped after reset");
                cyc(0, 1, 0, 32'h0000_0123, "");
                cyc(1, 0, 0, '0, "R3 load while stopped");
                cyc(0, 1, 1, 32'd1, "");
                idle(5);
                cyc(1, 0, 0, '0, "R4 start then R2 count");
                idle(2);
                cyc(1, 0, 0, '0, "R5 read keeps running");
                cyc(1, 0, 1, '0, "R6 read-and-halt value");
                idle(3);
                cyc(1, 0, 0, '0, "R6 holds returned value");
                cyc(0, 1, 1, 32'h0000_0003, "");
                idle(4);
                cyc(0, 1, 1, 32'hFFFF_FFFE, "");
                cyc(1, 0, 0, '0, "R4 stop via bit0 only");
                idle(2);
                cyc(1, 0, 0, '0, "R4 stays stopped");
                cyc(0, 1, 0, 32'hFFFF_FFFC, "");
                cyc(0, 1, 1, 32'd1, "");
                idle(6);
                cyc(1, 0, 0, '0, "R2 wrap past 2^32");
                cyc(0, 1, 0, 32'h0765_4321, "");
                cyc(1, 0, 0, '0, "R3 load while running");
                cyc(1, 0, 0, '0, "R3 resume from load");
                cyc(1, 1, 0, 32'h0000_0ABC, "R8 read+load returns old");
                cyc(1, 0, 0, '0, "R8 load applied");
                cyc(1, 1, 1, 32'd1, "R8 read+start returns count");
                idle(3);
                cyc(1, 0, 0, '0, "R8 start beats read halt");
                cyc(1, 1, 1, 32'd0, "R8 read+stop");
                idle(2);
                cyc(1, 0, 0, '0, "R8 stopped");
                cyc(0, 1, 0, 32'h07FF_FFF0, "");
                cyc(0, 1, 1, 32'd1, "");
                idle(40);
                cyc(1, 0, 1, '0, "R6 final halt");
                idle(3);
                done = 1'b1;
                check(exp_q.size() == 0, "R5 all reads answered", CNT_W'(exp_q.size()), '0);
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog expired", '0, '0);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule